// File: doc/BRIEF.md
# Processor-Side Interrupt Pending Collector

This block sits next to one processor and gathers interrupt requests for it. Requests reach it by two routes. The first is an interrupt packet from a shared system bus. Each packet carries a broadcast flag, a target identifier, a source identifier and a priority level. The second is a set of dedicated lines from sources on the same board, which raise a level directly without any packet decoding.

For each of fifteen priority levels the block keeps one pending bit and one source-identifier register. From the pending bits and a per-level mask it continuously presents the highest pending, unmasked level on a 4-bit output that feeds the processor's interrupt level input. Software has three controls:
- It writes the mask.
- It clears pending bits with a write-one-to-clear port.
- It finds out which bus source raised a level through a combinational read port indexed by level.

Top module: `irq_pend_rx`

## Requirements
- R1: A valid packet with `pkt_bcast` = 1 and a nonzero level is accepted whatever its target field holds.
- R2: A valid packet with `pkt_bcast` = 0 is accepted only when `pkt_target` equals `my_id`. Otherwise it changes neither the pending bits nor any source register.
- R3: An accepted packet of level L (1..15) sets pending bit L-1 and overwrites the source register of level L with `pkt_src`, one clock edge later. A packet with level 0 is ignored.
- R4: `local_set` bit k sets the pending bit of level k+1 at the next edge and leaves every source register unchanged.
- R5: `irq_level` equals the highest level L whose pending bit is set and which is not masked, or 0 when there is none. It follows the registered state with no added cycle.
- R6: `mask_wdata` bit k, loaded when `mask_we` is 1, masks level k+1 for levels 1..14. The mask bit of level 15 has no effect, so level 15 always reaches `irq_level`.
- R7: With `clr_we` = 1, every 1 in `clr_bits` (bit k is level k+1) clears that pending bit at the next edge. A set from either route on the same level in the same cycle wins over the clear.
- R8: A synchronous active-high `rst` clears all pending bits, the mask and all source registers, so `irq_level` reads 0.
- R9: `rd_src` returns the source register of level `rd_level` combinationally, and 0 when `rd_level` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| my_id | input | 8 | Identifier of this processor |
| pkt_valid | input | 1 | Packet present this cycle |
| pkt_bcast | input | 1 | Packet is for every processor |
| pkt_target | input | 8 | Target processor of a directed packet |
| pkt_src | input | 8 | Identifier of the interrupting source |
| pkt_level | input | 4 | Packet priority level, 0 means none |
| local_set | input | 15 | Direct set lines, bit k is level k+1 |
| mask_we | input | 1 | Load the mask register |
| mask_wdata | input | 15 | New mask, 1 masks a level |
| clr_we | input | 1 | Apply the clear vector |
| clr_bits | input | 15 | Write-one-to-clear pending bits |
| rd_level | input | 4 | Level whose source register is read |
| rd_src | output | 8 | Source register of `rd_level` |
| pend_o | output | 15 | Pending bits, bit k is level k+1 |
| irq_level | output | 4 | Highest pending unmasked level |

## Verification
The bench sends directed packets whose target differs from `my_id` and checks that neither the pending bits nor the source register moved. A filter that ignores the target would raise a bogus level there. It sends a level-0 broadcast, which an off-by-one in the level decode would turn into a level-15 or level-1 request. It then sends a second packet of an already pending level and checks that the source register follows the newest packet rather than holding the first.

Two further cases guard the mask and clear logic. Level 15 is raised under an all-ones mask, where a design that honours the top mask bit would present 0. A clear and a local set on the same level land in one cycle, where a clear-first design would drop the interrupt. A pseudo-random run then mixes all the inputs against an independent model.

// File: rtl/ipr_pkg.sv
package ipr_pkg;

    parameter int LVL_N = 15;
    parameter int LVL_W = $clog2(LVL_N + 1);
    parameter int ID_W  = 8;
    parameter int SRC_W = 8;

    typedef logic [LVL_N-1:0] lvl_vec_t;
    typedef logic [LVL_W-1:0] lvl_t;

    typedef struct packed {
        logic             bcast;
        logic [ID_W-1:0]  target;
        logic [SRC_W-1:0] src;
        lvl_t             level;
    } pkt_t;

    typedef struct packed {
        logic             hit;
        lvl_t             level;
        logic [SRC_W-1:0] src;
    } accept_t;

    // one-hot pending vector for a level, empty for level 0
    function automatic lvl_vec_t lvl_onehot(input lvl_t lvl);
        lvl_vec_t v;
        v = '0;
        for (int i = 0; i < LVL_N; i++) begin
            if (lvl == lvl_t'(i + 1)) v[i] = 1'b1;
        end
        return v;
    endfunction

    // highest set position of a vector, as a level number
    function automatic lvl_t top_level(input lvl_vec_t v);
        lvl_t r;
        r = '0;
        for (int i = 0; i < LVL_N; i++) begin
            if (v[i]) r = lvl_t'(i + 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/ipr_pkt_filter.sv
module ipr_pkt_filter
    import ipr_pkg::*;
(
    input  logic            pkt_valid,
    input  pkt_t            pkt,
    input  logic [ID_W-1:0] my_id,
    output accept_t         acc,
    output lvl_vec_t        pkt_set
);

    logic for_me;
    logic lvl_ok;

    always_comb begin
        for_me    = pkt.bcast || (pkt.target == my_id);
        lvl_ok    = (pkt.level != '0);
        acc.hit   = pkt_valid && for_me && lvl_ok;
        acc.level = pkt.level;
        acc.src   = pkt.src;
        pkt_set   = acc.hit ? lvl_onehot(pkt.level) : '0;
    end

endmodule

// File: rtl/ipr_level_bank.sv
module ipr_level_bank
    import ipr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  lvl_vec_t         set_vec,
    input  logic             clr_en,
    input  lvl_vec_t         clr_bits,
    input  accept_t          wr,
    input  lvl_t             rd_level,
    output logic [SRC_W-1:0] rd_src,
    output lvl_vec_t         pending_q
);

    logic [SRC_W-1:0] src_q [LVL_N];
    lvl_vec_t         clr_mask;

    assign clr_mask = clr_en ? clr_bits : '0;

    for (genvar i = 0; i < LVL_N; i++) begin : g_lvl
        // set takes priority over a clear in the same cycle
        always_ff @(posedge clk) begin
            if (rst)             pending_q[i] <= 1'b0;
            else if (set_vec[i]) pending_q[i] <= 1'b1;
            else if (clr_mask[i]) pending_q[i] <= 1'b0;
        end

        always_ff @(posedge clk) begin
            if (rst)
                src_q[i] <= '0;
            else if (wr.hit && wr.level == lvl_t'(i + 1))
                src_q[i] <= wr.src;
        end

        p_src_store_r3: assert property (@(posedge clk) disable iff (rst)
            (wr.hit && wr.level == lvl_t'(i + 1)) |=> (src_q[i] == $past(wr.src)));

        p_src_keep_r4: assert property (@(posedge clk) disable iff (rst)
            !(wr.hit && wr.level == lvl_t'(i + 1)) |=> $stable(src_q[i]));
    end

    always_comb begin
        rd_src = '0;
        for (int i = 0; i < LVL_N; i++) begin
            if (rd_level == lvl_t'(i + 1)) rd_src = src_q[i];
        end
    end

    p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((pending_q & $past(set_vec)) == $past(set_vec)));

    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> ((pending_q & $past(clr_bits & ~set_vec)) == '0));

endmodule

// File: rtl/ipr_prio_sel.sv
module ipr_prio_sel
    import ipr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     mask_we,
    input  lvl_vec_t mask_wdata,
    input  lvl_vec_t pending,
    output lvl_t     irq_level
);

    lvl_vec_t mask_q;
    lvl_vec_t enable;

    always_ff @(posedge clk) begin
        if (rst)          mask_q <= '0;
        else if (mask_we) mask_q <= mask_wdata;
    end

    for (genvar i = 0; i < LVL_N; i++) begin : g_en
        if (i == LVL_N - 1) begin : g_top
            assign enable[i] = 1'b1;
        end else begin : g_low
            assign enable[i] = ~mask_q[i];
        end
    end

    assign irq_level = top_level(pending & enable);

    p_irq_pending_r5: assert property (@(posedge clk) disable iff (rst)
        (irq_level != '0) |-> pending[irq_level - lvl_t'(1)]);

    p_irq_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (irq_level == '0) |-> ((pending & ~mask_q) == '0) && !pending[LVL_N-1]);

    p_top_unmasked_r6: assert property (@(posedge clk) disable iff (rst)
        pending[LVL_N-1] |-> (irq_level == lvl_t'(LVL_N)));

endmodule

// File: rtl/irq_pend_rx.sv
module irq_pend_rx
    import ipr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [ID_W-1:0]  my_id,
    input  logic             pkt_valid,
    input  logic             pkt_bcast,
    input  logic [ID_W-1:0]  pkt_target,
    input  logic [SRC_W-1:0] pkt_src,
    input  logic [LVL_W-1:0] pkt_level,
    input  logic [LVL_N-1:0] local_set,
    input  logic             mask_we,
    input  logic [LVL_N-1:0] mask_wdata,
    input  logic             clr_we,
    input  logic [LVL_N-1:0] clr_bits,
    input  logic [LVL_W-1:0] rd_level,
    output logic [SRC_W-1:0] rd_src,
    output logic [LVL_N-1:0] pend_o,
    output logic [LVL_W-1:0] irq_level
);

    pkt_t     pkt;
    accept_t  acc;
    lvl_vec_t pkt_set;
    lvl_vec_t set_all;

    assign pkt.bcast  = pkt_bcast;
    assign pkt.target = pkt_target;
    assign pkt.src    = pkt_src;
    assign pkt.level  = pkt_level;

    ipr_pkt_filter u_filter (
        .pkt_valid (pkt_valid),
        .pkt       (pkt),
        .my_id     (my_id),
        .acc       (acc),
        .pkt_set   (pkt_set)
    );

    assign set_all = pkt_set | local_set;

    ipr_level_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .set_vec   (set_all),
        .clr_en    (clr_we),
        .clr_bits  (clr_bits),
        .wr        (acc),
        .rd_level  (rd_level),
        .rd_src    (rd_src),
        .pending_q (pend_o)
    );

    ipr_prio_sel u_prio (
        .clk        (clk),
        .rst        (rst),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .pending    (pend_o),
        .irq_level  (irq_level)
    );

    p_bcast_take_r1: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && pkt_bcast && pkt_level != '0)
        |=> ((pend_o & lvl_onehot($past(pkt_level))) != '0));

    p_miss_inert_r2: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && !pkt_bcast && pkt_target != my_id && local_set == '0 && !clr_we)
        |=> $stable(pend_o));

    p_zero_level_r3: assert property (@(posedge clk) disable iff (rst)
        (local_set == '0 && !clr_we && (!pkt_valid || pkt_level == '0))
        |=> $stable(pend_o));

endmodule

// File: tb/tb_irq_pend_rx.sv
module tb_irq_pend_rx;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  my_id = 8'h2A;
    logic        pkt_valid, pkt_bcast;
    logic [7:0]  pkt_target, pkt_src;
    logic [3:0]  pkt_level;
    logic [14:0] local_set, mask_wdata, clr_bits;
    logic        mask_we, clr_we;
    logic [3:0]  rd_level;
    logic [7:0]  rd_src;
    logic [14:0] pend_o;
    logic [3:0]  irq_level;

    always #(CLK_P/2) clk = ~clk;

    irq_pend_rx dut (
        .clk(clk), .rst(rst), .my_id(my_id),
        .pkt_valid(pkt_valid), .pkt_bcast(pkt_bcast), .pkt_target(pkt_target),
        .pkt_src(pkt_src), .pkt_level(pkt_level), .local_set(local_set),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .clr_we(clr_we),
        .clr_bits(clr_bits), .rd_level(rd_level), .rd_src(rd_src),
        .pend_o(pend_o), .irq_level(irq_level)
    );

    typedef struct {
        logic [3:0]  irq;
        logic [14:0] pend;
        logic [7:0]  src;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 0;

    // reference state
    logic [14:0] m_pend, m_mask;
    logic [7:0]  m_src [1:15];

    function automatic logic [3:0] m_irq();
        for (int l = 15; l >= 1; l--) begin
            if (m_pend[l-1] && (l == 15 || !m_mask[l-1])) return 4'(l);
        end
        return 4'd0;
    endfunction

    task automatic model_step();
        logic        take;
        logic [14:0] setv;
        if (rst) begin
            m_pend = '0;
            m_mask = '0;
            for (int l = 1; l <= 15; l++) m_src[l] = 8'h00;
            return;
        end
        take = pkt_valid && (pkt_level != 0) && (pkt_bcast || pkt_target == my_id);
        setv = local_set;
        if (take) begin
            setv[pkt_level-1] = 1'b1;
            m_src[pkt_level]  = pkt_src;
        end
        m_pend = (m_pend & ~(clr_we ? clr_bits : 15'h0)) | setv;
        if (mask_we) m_mask = mask_wdata;
    endtask

    task automatic clear_pulses();
        rst = 0; pkt_valid = 0; pkt_bcast = 0; pkt_target = 0; pkt_src = 0;
        pkt_level = 0; local_set = 0; mask_we = 0; mask_wdata = 0;
        clr_we = 0; clr_bits = 0;
    endtask

    // driver: inputs already set; one clock, then push the expected outcome
    task automatic cycle(input string tag);
        exp_t e;
        @(posedge clk);
        model_step();
        e.irq  = m_irq();
        e.pend = m_pend;
        e.src  = (rd_level == 0) ? 8'h00 : m_src[rd_level];
        e.tag  = tag;
        q.push_back(e);
        @(negedge clk);
        #1;
        clear_pulses();
    endtask

    // monitor
    always @(negedge clk) begin
        exp_t e;
        if (q.size() > 0) begin
            e = q.pop_front();
            checks++;
            if (irq_level !== e.irq) begin
                fails++;
                $display("FAIL %s irq_level actual=%0d expected=%0d", e.tag, irq_level, e.irq);
            end
            checks++;
            if (pend_o !== e.pend) begin
                fails++;
                $display("FAIL %s pend_o actual=%h expected=%h", e.tag, pend_o, e.pend);
            end
            checks++;
            if (rd_src !== e.src) begin
                fails++;
                $display("FAIL %s rd_src actual=%h expected=%h", e.tag, rd_src, e.src);
            end
        end
    end

    task automatic send(input logic b, input logic [7:0] t, input logic [7:0] s,
                        input logic [3:0] l);
        pkt_valid = 1; pkt_bcast = b; pkt_target = t; pkt_src = s; pkt_level = l;
    endtask

    initial begin
        #(CLK_P * 200000);
        fails++;
        checks++;
        $display("FAIL R8 watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        clear_pulses();
        rd_level = 0;
        #1;
        rst = 1;
        cycle("R8");                       // reset state
        rst = 1;
        cycle("R8");

        rd_level = 5;  send(1, 8'h11, 8'h21, 4'd5);  cycle("R1");  // broadcast, foreign target
        rd_level = 9;  send(0, 8'h2A, 8'h33, 4'd9);  cycle("R2");  // directed hit
        rd_level = 12; send(0, 8'h2B, 8'h44, 4'd12); cycle("R2");  // directed miss
        rd_level = 0;  send(1, 8'h00, 8'h66, 4'd0);  cycle("R3");  // level 0 ignored
        cycle("R9");
        rd_level = 5;  send(1, 8'h2A, 8'h55, 4'd5);  cycle("R3");  // overwrite source
        rd_level = 3;  local_set = 15'h0004;         cycle("R4");  // local level 3
        mask_we = 1; mask_wdata = 15'h0100;          cycle("R6");  // mask level 9
        local_set = 15'h4000; mask_we = 1; mask_wdata = 15'h7FFF;  cycle("R6");
        clr_we = 1; clr_bits = 15'h4000;             cycle("R7");  // clear level 15
        clr_we = 1; clr_bits = 15'h0008; local_set = 15'h0008;     cycle("R7");
        rd_level = 9; clr_we = 1; clr_bits = 15'h0100;
        send(0, 8'h2A, 8'h77, 4'd9);                 cycle("R7");  // packet set beats clear
        mask_we = 1; mask_wdata = 15'h0000;          cycle("R5");
        clr_we = 1; clr_bits = 15'h7FFF;             cycle("R7");
        cycle("R5");

        lf = 16'hACE1;
        for (int n = 0; n < 60; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (lf[0]) send(lf[1], lf[2] ? 8'h2A : {4'h1, lf[7:4]}, lf[15:8], lf[11:8]);
            if (lf[3] && lf[6]) local_set = 15'(1) << lf[10:7];
            if (lf[12] && lf[5]) begin clr_we = 1; clr_bits = {lf[14:0]}; end
            if (lf[9] && lf[13]) begin mask_we = 1; mask_wdata = {lf[0], lf[15:2]}; end
            rd_level = lf[15:12];
            cycle("R5");
        end

        rd_level = 5; send(1, 8'h00, 8'h99, 4'd5); cycle("R1");
        rst = 1;                                   cycle("R8");

        @(negedge clk);
        #1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule